// File: doc/BRIEF.md
# Hardware Cursor Overlay with Frame-Synchronous Update

This block lays a small cursor image over the pixel stream produced by a display timing generator. For every pixel the timing generator presents its screen coordinates and the background colour. When the coordinates fall inside the cursor rectangle, a 2-bit code read from a local image RAM decides the output. The code can let the background through, replace it with one of two fixed colours, or invert it.

The cursor position, size and enable are written by a register side into a pending copy. The pending copy is moved into the live copy only on a frame-done pulse, so a cursor that is half drawn never moves or changes size within a frame. A write of zero width or zero height is the exception: it switches the cursor off at once. The image RAM is loaded through an auto-incrementing write port that is split into banks. Whenever the RAM leaves its sleep (power-down) state, and after reset, the RAM refills itself with a fixed pattern. In interlaced operation each field shows half the programmed height.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the live enable is 0, the live position and live size read back as 0, and the pixel output equals the background input.
- R2: A register write with a legal non-zero size stores position (y in bits 31:16, x in bits 15:0), size (height in bits 31:16, width in bits 15:0) and enable as pending. The live readback keeps its old values until a frame-done pulse arrives while an update is pending. The live values change in the cycle after that pulse and the pending flag clears. A frame-done pulse with nothing pending changes nothing.
- R3: A size is legal only when width and height are each at most MAX_DIM and they are not both above SMALL_DIM. A write with an illegal non-zero size is ignored and leaves the pending and live state untouched.
- R4: A register write whose width or height is zero clears the live enable in the next cycle without waiting for frame done, and cancels any pending update. The live position and size are kept.
- R5: A pixel is inside the cursor when the live enable is 1, x ≤ hcount < x+w and y ≤ vcount < y+h_eff. Outside the cursor the output is the background. The output is registered one cycle after the coordinates and background are presented.
- R6: The code of cursor pixel (cx, cy) sits in RAM word cy·(MAX_DIM/P) + cx/P, bits 2·(cx mod P)+1 : 2·(cx mod P), where P = WORD_W/2. Code 00 passes the background, 01 gives colour A, 10 gives colour B and 11 gives the bitwise inverse of the background.
- R7: With interlaced high, h_eff is the live height halved and rounded down. The live size readback is unaffected.
- R8: Loading an address sets the write pointer. Each accepted write stores one word and advances the pointer. When the in-bank offset wraps from BANK_WORDS-1 to 0, the bank advances, and the last bank wraps to bank 0.
- R9: After reset and after every fall of the sleep input, every RAM word is rewritten with the pattern 01 in each 2-bit code, one word per cycle over all words. Port writes made during this refill are dropped.
- R10: While sleep is high the cursor pixels show the background and port writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Strobe that captures reg_pos, reg_size and reg_en |
| reg_pos | input | 32 | Requested screen position, y in 31:16, x in 15:0 |
| reg_size | input | 32 | Requested size, height in 31:16, width in 15:0 |
| reg_en | input | 1 | Requested cursor enable |
| frame_done | input | 1 | One-cycle end-of-frame pulse that commits pending values |
| interlaced | input | 1 | Field mode: halves the displayed height |
| live_pos | output | 32 | Committed position readback |
| live_size | output | 32 | Committed size readback |
| live_en | output | 1 | Committed enable readback |
| ram_sleep | input | 1 | Image RAM power-down |
| ram_addr_ld | input | 1 | Load the write pointer from ram_addr |
| ram_addr | input | ADDR_W | Start word address for image loading |
| ram_wr | input | 1 | Write ram_wdata at the pointer and advance |
| ram_wdata | input | WORD_W | Image word, WORD_W/2 codes |
| colour_a | input | PIX_W | Colour for code 01 |
| colour_b | input | PIX_W | Colour for code 10 |
| hcount | input | COORD_W | Current pixel column |
| vcount | input | COORD_W | Current pixel line |
| bg_pix | input | PIX_W | Background pixel |
| pix_out | output | PIX_W | Pixel with the cursor applied |

## Verification
The bench builds the block with a 16-pixel maximum dimension, an 8-pixel small limit, 8-bit words and 32-word banks. With these values the whole image is 64 words over two banks. Full screen sweeps of a 32×24 area can therefore cover every cursor pixel, every rectangle edge, the bank crossing at row 8 and both asymmetric shapes (16×8 and 8×16). The same small image fits a refill of under a hundred cycles, so sleep, refill and dropped writes can be tried at several moments. Expected pixels come from an arithmetic model of the rectangle, the word layout and the code mapping.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

   localparam int FIELD_W = 16;

   typedef enum logic [1:0] {
      CODE_CLEAR  = 2'b00,
      CODE_INK_A  = 2'b01,
      CODE_INK_B  = 2'b10,
      CODE_INVERT = 2'b11
   } cur_code_e;

   // legal shape: each side within the large limit, not both above the small one
   function automatic logic shape_ok(input logic [FIELD_W-1:0] w,
                                     input logic [FIELD_W-1:0] h,
                                     input int big_lim,
                                     input int small_lim);
      logic w_fit, h_fit, both_wide;
      w_fit     = (32'(w) <= big_lim);
      h_fit     = (32'(h) <= big_lim);
      both_wide = (32'(w) > small_lim) && (32'(h) > small_lim);
      return w_fit && h_fit && !both_wide;
   endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
   import cursor_ovl_pkg::*;
#(
   parameter int SZ_W      = 7,
   parameter int MAX_DIM   = 64,
   parameter int SMALL_DIM = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [31:0]        reg_pos,
   input  logic [31:0]        reg_size,
   input  logic               reg_en,
   input  logic               frame_done,
   output logic [FIELD_W-1:0] live_x,
   output logic [FIELD_W-1:0] live_y,
   output logic [SZ_W-1:0]    live_w,
   output logic [SZ_W-1:0]    live_h,
   output logic               live_on
);

   logic [FIELD_W-1:0] req_w, req_h;
   logic               req_zero, req_legal;

   logic [FIELD_W-1:0] pend_x, pend_y;
   logic [SZ_W-1:0]    pend_w, pend_h;
   logic               pend_on, pending;

   assign req_w     = reg_size[FIELD_W-1:0];
   assign req_h     = reg_size[2*FIELD_W-1:FIELD_W];
   assign req_zero  = (req_w == '0) || (req_h == '0);
   assign req_legal = shape_ok(req_w, req_h, MAX_DIM, SMALL_DIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_x  <= '0;
         pend_y  <= '0;
         pend_w  <= '0;
         pend_h  <= '0;
         pend_on <= 1'b0;
         pending <= 1'b0;
         live_x  <= '0;
         live_y  <= '0;
         live_w  <= '0;
         live_h  <= '0;
         live_on <= 1'b0;
      end else begin
         if (frame_done && pending) begin
            live_x  <= pend_x;
            live_y  <= pend_y;
            live_w  <= pend_w;
            live_h  <= pend_h;
            live_on <= pend_on;
            pending <= 1'b0;
         end
         if (reg_wr) begin
            if (req_zero) begin
               live_on <= 1'b0;
               pending <= 1'b0;
            end else if (req_legal) begin
               pend_x  <= reg_pos[FIELD_W-1:0];
               pend_y  <= reg_pos[2*FIELD_W-1:FIELD_W];
               pend_w  <= SZ_W'(req_w);
               pend_h  <= SZ_W'(req_h);
               pend_on <= reg_en;
               pending <= 1'b1;
            end
         end
      end
   end

   // R2: commit copies the pending set taken before the pulse
   assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && pending) |=>
         ({live_x, live_y, live_w, live_h} == $past({pend_x, pend_y, pend_w, pend_h})));

   // R2: without a commit the live geometry never moves
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_done && pending) |=> $stable({live_x, live_y, live_w, live_h}));

   // R4: zero-size write switches the cursor off at once
   assert_zero_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && req_zero) |=> !live_on);

   // R3: a shown cursor always has a legal, non-empty shape
   assert_live_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      live_on |-> (shape_ok(FIELD_W'(live_w), FIELD_W'(live_h), MAX_DIM, SMALL_DIM)
                   && (live_w != '0) && (live_h != '0)));

endmodule

// File: rtl/cursor_ram.sv
module cursor_ram #(
   parameter int WORD_W     = 16,
   parameter int BANK_WORDS = 256,
   parameter int NUM_BANKS  = 2,
   parameter int ADDR_W     = 9
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              addr_ld,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   localparam int OFF_W  = $clog2(BANK_WORDS);
   localparam int BANK_W = $clog2(NUM_BANKS);
   localparam int TOTAL  = BANK_WORDS * NUM_BANKS;
   localparam logic [WORD_W-1:0] FILL = {(WORD_W/2){2'b01}};

   if ((1 << OFF_W) != BANK_WORDS || (1 << BANK_W) != NUM_BANKS || NUM_BANKS < 2)
      begin : g_bad_banks
         $error("cursor_ram: bank count and size must be powers of two, two banks or more");
      end
   if (OFF_W + BANK_W != ADDR_W) begin : g_bad_addr
      $error("cursor_ram: ADDR_W does not match the bank geometry");
   end

   logic [WORD_W-1:0] mem [TOTAL];

   logic [OFF_W-1:0]  ptr_off;
   logic [BANK_W-1:0] ptr_bank;
   logic [ADDR_W-1:0] ptr_lin;
   logic              init_busy, sleep_q;
   logic [ADDR_W-1:0] init_idx;
   logic              user_ok, mem_we;
   logic [ADDR_W-1:0] mem_wa;
   logic [WORD_W-1:0] mem_wd;

   assign ptr_lin = {ptr_bank, ptr_off};
   assign user_ok = !sleep && !sleep_q && !init_busy;
   assign mem_we  = (!sleep && init_busy) || (user_ok && wr_en);
   assign mem_wa  = init_busy ? init_idx : ptr_lin;
   assign mem_wd  = init_busy ? FILL : wr_data;

   always_ff @(posedge clk) begin
      if (mem_we) mem[mem_wa] <= mem_wd;
   end

   assign rd_data = sleep ? '0 : mem[rd_addr];

   // refill sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_busy <= 1'b1;
         init_idx  <= '0;
         sleep_q   <= 1'b1;
      end else begin
         sleep_q <= sleep;
         if (sleep) begin
            init_busy <= 1'b0;
         end else if (sleep_q) begin
            init_busy <= 1'b1;
            init_idx  <= '0;
         end else if (init_busy) begin
            init_idx <= init_idx + 1'b1;
            if (init_idx == ADDR_W'(TOTAL - 1)) init_busy <= 1'b0;
         end
      end
   end

   // bank-split write pointer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_off  <= '0;
         ptr_bank <= '0;
      end else if (addr_ld) begin
         ptr_off  <= addr_in[OFF_W-1:0];
         ptr_bank <= addr_in[ADDR_W-1:OFF_W];
      end else if (wr_en && user_ok) begin
         ptr_off <= ptr_off + 1'b1;
         if (ptr_off == OFF_W'(BANK_WORDS - 1)) begin
            ptr_bank <= (ptr_bank == BANK_W'(NUM_BANKS - 1)) ? '0 : ptr_bank + 1'b1;
         end
      end
   end

   // R8: an accepted write moves to the next word, across banks included
   assert_ptr_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && user_ok && !addr_ld) |=> (ptr_lin == $past(ptr_lin) + 1'b1));

   // R9: leaving sleep restarts the refill from word zero
   assert_refill_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep) |=> (init_busy && init_idx == '0));

endmodule

// File: rtl/cursor_pixel.sv
module cursor_pixel
   import cursor_ovl_pkg::*;
#(
   parameter int COORD_W   = 12,
   parameter int SZ_W      = 7,
   parameter int PIX_W     = 24,
   parameter int MAX_DIM   = 64,
   parameter int WORD_W    = 16,
   parameter int ADDR_W    = 9,
   parameter int OUT_STAGE = 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COORD_W-1:0] hcount,
   input  logic [COORD_W-1:0] vcount,
   input  logic [PIX_W-1:0]   bg_pix,
   input  logic               interlaced,
   input  logic [FIELD_W-1:0] live_x,
   input  logic [FIELD_W-1:0] live_y,
   input  logic [SZ_W-1:0]    live_w,
   input  logic [SZ_W-1:0]    live_h,
   input  logic               live_on,
   input  logic [PIX_W-1:0]   colour_a,
   input  logic [PIX_W-1:0]   colour_b,
   input  logic [WORD_W-1:0]  rd_data,
   output logic [ADDR_W-1:0]  rd_addr,
   output logic [PIX_W-1:0]   pix_out
);

   localparam int DIM_W = $clog2(MAX_DIM);
   localparam int PPW   = WORD_W / 2;
   localparam int SEL_W = $clog2(PPW);
   localparam int CMP_W = FIELD_W + 1;

   if (2 * DIM_W - SEL_W != ADDR_W) begin : g_bad_layout
      $error("cursor_pixel: image layout does not match ADDR_W");
   end

   logic [SZ_W-1:0]   h_eff;
   logic [CMP_W-1:0]  x_end, y_end, hc_w, vc_w;
   logic              in_x, in_y, hit;
   logic [DIM_W-1:0]  cx, cy;
   cur_code_e         code;
   logic [PIX_W-1:0]  pix_next;

   assign h_eff = interlaced ? (live_h >> 1) : live_h;
   assign hc_w  = CMP_W'(hcount);
   assign vc_w  = CMP_W'(vcount);
   assign x_end = CMP_W'(live_x) + CMP_W'(live_w);
   assign y_end = CMP_W'(live_y) + CMP_W'(h_eff);
   assign in_x  = (hc_w >= CMP_W'(live_x)) && (hc_w < x_end);
   assign in_y  = (vc_w >= CMP_W'(live_y)) && (vc_w < y_end);
   assign hit   = live_on && in_x && in_y;

   assign cx      = DIM_W'(hcount) - DIM_W'(live_x);
   assign cy      = DIM_W'(vcount) - DIM_W'(live_y);
   assign rd_addr = {cy, cx[DIM_W-1:SEL_W]};
   assign code    = cur_code_e'(rd_data[{cx[SEL_W-1:0], 1'b0} +: 2]);

   always_comb begin
      pix_next = bg_pix;
      if (hit) begin
         unique case (code)
            CODE_CLEAR:  pix_next = bg_pix;
            CODE_INK_A:  pix_next = colour_a;
            CODE_INK_B:  pix_next = colour_b;
            CODE_INVERT: pix_next = ~bg_pix;
         endcase
      end
   end

   if (OUT_STAGE != 0) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) pix_out <= '0;
         else        pix_out <= pix_next;
      end

      // R5: pixels outside the rectangle come out as the background
      assert_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !hit |=> (pix_out == $past(bg_pix)));
   end else begin : g_comb_out
      assign pix_out = pix_next;
   end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_ovl_pkg::*;
#(
   parameter int COORD_W    = 12,
   parameter int PIX_W      = 24,
   parameter int MAX_DIM    = 64,
   parameter int SMALL_DIM  = 32,
   parameter int WORD_W     = 16,
   parameter int BANK_WORDS = 256,
   parameter int OUT_STAGE  = 1,
   localparam int DIM_W     = $clog2(MAX_DIM),
   localparam int SZ_W      = DIM_W + 1,
   localparam int PPW       = WORD_W / 2,
   localparam int TOTAL     = MAX_DIM * MAX_DIM / PPW,
   localparam int NUM_BANKS = TOTAL / BANK_WORDS,
   localparam int ADDR_W    = $clog2(TOTAL)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [31:0]        reg_pos,
   input  logic [31:0]        reg_size,
   input  logic               reg_en,
   input  logic               frame_done,
   input  logic               interlaced,
   output logic [31:0]        live_pos,
   output logic [31:0]        live_size,
   output logic               live_en,
   input  logic               ram_sleep,
   input  logic               ram_addr_ld,
   input  logic [ADDR_W-1:0]  ram_addr,
   input  logic               ram_wr,
   input  logic [WORD_W-1:0]  ram_wdata,
   input  logic [PIX_W-1:0]   colour_a,
   input  logic [PIX_W-1:0]   colour_b,
   input  logic [COORD_W-1:0] hcount,
   input  logic [COORD_W-1:0] vcount,
   input  logic [PIX_W-1:0]   bg_pix,
   output logic [PIX_W-1:0]   pix_out
);

   if ((1 << DIM_W) != MAX_DIM || SMALL_DIM >= MAX_DIM || SMALL_DIM < 1) begin : g_bad_dim
      $error("cursor_overlay: MAX_DIM must be a power of two above SMALL_DIM");
   end
   if (WORD_W < 4 || (1 << $clog2(PPW)) != PPW || PPW > MAX_DIM) begin : g_bad_word
      $error("cursor_overlay: WORD_W must hold a power-of-two count of codes");
   end
   if (COORD_W > FIELD_W || TOTAL % BANK_WORDS != 0) begin : g_bad_misc
      $error("cursor_overlay: coordinate width or bank size out of range");
   end

   logic [FIELD_W-1:0] lx, ly;
   logic [SZ_W-1:0]    lw, lh;
   logic               lon;
   logic [ADDR_W-1:0]  rd_addr;
   logic [WORD_W-1:0]  rd_data;

   cursor_regs #(
      .SZ_W(SZ_W), .MAX_DIM(MAX_DIM), .SMALL_DIM(SMALL_DIM)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_pos(reg_pos),
      .reg_size(reg_size), .reg_en(reg_en), .frame_done(frame_done),
      .live_x(lx), .live_y(ly), .live_w(lw), .live_h(lh), .live_on(lon)
   );

   cursor_ram #(
      .WORD_W(WORD_W), .BANK_WORDS(BANK_WORDS), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
   ) u_ram (
      .clk(clk), .rst_n(rst_n), .sleep(ram_sleep), .addr_ld(ram_addr_ld),
      .addr_in(ram_addr), .wr_en(ram_wr), .wr_data(ram_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   cursor_pixel #(
      .COORD_W(COORD_W), .SZ_W(SZ_W), .PIX_W(PIX_W), .MAX_DIM(MAX_DIM),
      .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OUT_STAGE(OUT_STAGE)
   ) u_pixel (
      .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount), .bg_pix(bg_pix),
      .interlaced(interlaced), .live_x(lx), .live_y(ly), .live_w(lw), .live_h(lh),
      .live_on(lon), .colour_a(colour_a), .colour_b(colour_b),
      .rd_data(rd_data), .rd_addr(rd_addr), .pix_out(pix_out)
   );

   assign live_pos  = {ly, lx};
   assign live_size = {FIELD_W'(lh), FIELD_W'(lw)};
   assign live_en   = lon;

endmodule

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;

   localparam int CLK_PERIOD = 10;
   localparam int T_DIM   = 16;
   localparam int T_SMALL = 8;
   localparam int T_WORD  = 8;
   localparam int T_BANK  = 32;
   localparam int T_PPW   = T_WORD / 2;
   localparam int T_WPR   = T_DIM / T_PPW;
   localparam int T_TOTAL = T_DIM * T_DIM / T_PPW;
   localparam int T_AW    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_en = 1'b0, frame_done = 1'b0, interlaced = 1'b0;
   logic [31:0] reg_pos = '0, reg_size = '0;
   logic [31:0] live_pos, live_size;
   logic live_en;
   logic ram_sleep = 1'b0, ram_addr_ld = 1'b0, ram_wr = 1'b0;
   logic [T_AW-1:0] ram_addr = '0;
   logic [T_WORD-1:0] ram_wdata = '0;
   logic [7:0] colour_a = 8'hC3, colour_b = 8'h3C;
   logic [7:0] hcount = '0, vcount = '0, bg_pix = '0;
   logic [7:0] pix_out;

   int n_chk = 0, n_err = 0;

   // bench model
   logic [T_WORD-1:0] mdl [T_TOTAL];
   int m_x = 0, m_y = 0, m_w = 0, m_h = 0;
   logic m_en = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cursor_overlay #(
      .COORD_W(8), .PIX_W(8), .MAX_DIM(T_DIM), .SMALL_DIM(T_SMALL),
      .WORD_W(T_WORD), .BANK_WORDS(T_BANK), .OUT_STAGE(1)
   ) i_cursor_overlay (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_pos(reg_pos),
      .reg_size(reg_size), .reg_en(reg_en), .frame_done(frame_done),
      .interlaced(interlaced), .live_pos(live_pos), .live_size(live_size),
      .live_en(live_en), .ram_sleep(ram_sleep), .ram_addr_ld(ram_addr_ld),
      .ram_addr(ram_addr), .ram_wr(ram_wr), .ram_wdata(ram_wdata),
      .colour_a(colour_a), .colour_b(colour_b), .hcount(hcount),
      .vcount(vcount), .bg_pix(bg_pix), .pix_out(pix_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_live(input string req);
      chk(req, live_pos, (32'(m_y) << 16) | 32'(m_x));
      chk(req, live_size, (32'(m_h) << 16) | 32'(m_w));
      chk(req, {31'd0, live_en}, {31'd0, m_en});
   endtask

   task automatic reg_write(input logic [31:0] pos, input logic [31:0] size, input logic en);
      @(negedge clk);
      reg_pos = pos; reg_size = size; reg_en = en; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic frame();
      @(negedge clk);
      frame_done = 1'b1;
      @(negedge clk);
      frame_done = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [7:0] exp_pix(input int h, input int v, input logic [7:0] bg);
      int he, cx, cy;
      logic [1:0] code;
      he = interlaced ? m_h / 2 : m_h;
      if (m_en && h >= m_x && h < m_x + m_w && v >= m_y && v < m_y + he) begin
         cx = h - m_x;
         cy = v - m_y;
         code = 2'(mdl[cy * T_WPR + cx / T_PPW] >> (2 * (cx % T_PPW)));
         case (code)
            2'b00:   return bg;
            2'b01:   return colour_a;
            2'b10:   return colour_b;
            default: return ~bg;
         endcase
      end
      return bg;
   endfunction

   task automatic px(input string req, input int h, input int v);
      logic [7:0] bg;
      bg = 8'(h ^ (v << 3) ^ 8'h5A);
      @(negedge clk);
      hcount = 8'(h); vcount = 8'(v); bg_pix = bg;
      @(posedge clk);
      #1;
      chk(req, {24'd0, pix_out}, {24'd0, exp_pix(h, v, bg)});
   endtask

   task automatic sweep(input string req);
      for (int v = 0; v < 24; v++)
         for (int h = 0; h < 32; h++)
            px(req, h, v);
   endtask

   task automatic fill_model();
      for (int i = 0; i < T_TOTAL; i++) mdl[i] = 8'h55;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] keep_size;
      fill_model();
      idle(3);
      rst_n = 1'b1;
      // R1: reset state
      chk_live("R1 reset live values");
      px("R1 reset passes background", 3, 3);
      idle(2 * T_TOTAL);

      // R2: pending only until frame done
      reg_write(32'h0003_0002, 32'h0004_0004, 1'b1);
      chk_live("R2 live held before frame done");
      idle(3);
      px("R2 cursor hidden before commit", 3, 4);
      frame();
      m_x = 2; m_y = 3; m_w = 4; m_h = 4; m_en = 1'b1;
      chk_live("R2 commit at frame done");
      // R9: pattern after reset gives colour A everywhere
      px("R9 refill pattern after reset", 2, 3);
      px("R9 refill pattern far corner", 5, 6);
      px("R5 right edge exclusive", 6, 3);
      px("R5 bottom edge exclusive", 2, 7);
      frame();
      chk_live("R2 frame done with nothing pending");

      // R8: load whole image, crossing the bank and wrapping to bank 0
      @(negedge clk);
      ram_addr = '0; ram_addr_ld = 1'b1;
      @(negedge clk);
      ram_addr_ld = 1'b0;
      for (int i = 0; i < T_TOTAL + 1; i++) begin
         ram_wdata = 8'((i * 37 + 11) ^ (i >> 2));
         mdl[i % T_TOTAL] = ram_wdata;
         ram_wr = 1'b1;
         @(negedge clk);
      end
      ram_wr = 1'b0;
      ram_addr = 6'd40; ram_addr_ld = 1'b1;
      @(negedge clk);
      ram_addr_ld = 1'b0;
      for (int i = 0; i < 2; i++) begin
         ram_wdata = 8'hE4 ^ 8'(i);
         mdl[40 + i] = ram_wdata;
         ram_wr = 1'b1;
         @(negedge clk);
      end
      ram_wr = 1'b0;

      // R5/R6: wide shape at the limits
      reg_write(32'h0004_0005, 32'h0008_0010, 1'b1);
      frame();
      m_x = 5; m_y = 4; m_w = 16; m_h = 8;
      chk_live("R3 wide legal shape accepted");
      sweep("R6 sweep wide shape");
      // R8: tall shape covers bank 1 rows
      reg_write(32'h0002_0014, 32'h0010_0008, 1'b1);
      frame();
      m_x = 20; m_y = 2; m_w = 8; m_h = 16;
      chk_live("R3 tall legal shape accepted");
      sweep("R8 sweep tall shape across banks");

      // R7: interlaced halves the height
      @(negedge clk);
      interlaced = 1'b1;
      sweep("R7 sweep interlaced");
      chk("R7 size readback unchanged", live_size, 32'h0010_0008);
      reg_write(32'h0000_0000, 32'h0005_0008, 1'b1);
      frame();
      m_x = 0; m_y = 0; m_w = 8; m_h = 5;
      px("R7 odd height row inside", 1, 1);
      px("R7 odd height row outside", 1, 2);
      @(negedge clk);
      interlaced = 1'b0;
      px("R7 progressive row shown", 1, 2);

      // R3: illegal shapes ignored
      keep_size = live_size;
      reg_write(32'h0001_0001, 32'h0010_0010, 1'b1);
      frame();
      chk("R3 both sides above small limit", live_size, keep_size);
      reg_write(32'h0001_0001, 32'h0001_0011, 1'b1);
      frame();
      chk("R3 width above limit", live_size, keep_size);
      reg_write(32'h0001_0001, 32'h0011_0001, 1'b1);
      frame();
      chk("R3 height above limit", live_size, keep_size);
      chk("R3 position untouched", live_pos, 32'h0000_0000);

      // R4: zero size switches off at once and cancels pending
      reg_write(32'h0006_0006, 32'h0004_0004, 1'b1);
      reg_write(32'h0006_0006, 32'h0000_0004, 1'b1);
      m_en = 1'b0;
      chk_live("R4 zero height off immediately");
      px("R4 cursor gone", 1, 1);
      frame();
      chk_live("R4 pending cancelled");

      // R2: deferred disable
      reg_write(32'h0001_0001, 32'h0004_0004, 1'b1);
      frame();
      m_x = 1; m_y = 1; m_w = 4; m_h = 4; m_en = 1'b1;
      reg_write(32'h0001_0001, 32'h0004_0004, 1'b0);
      chk_live("R2 disable waits for frame done");
      px("R2 still shown", 2, 2);
      frame();
      m_en = 1'b0;
      chk_live("R2 disable committed");
      px("R2 hidden after commit", 2, 2);

      // R10: sleep makes cursor transparent; R9: refill and dropped writes
      reg_write(32'h0000_0000, 32'h0004_0004, 1'b1);
      frame();
      m_x = 0; m_y = 0; m_w = 4; m_h = 4; m_en = 1'b1;
      @(negedge clk);
      ram_sleep = 1'b1;
      for (int i = 0; i < T_TOTAL; i++) mdl[i] = 8'h00;
      px("R10 sleeping RAM transparent", 0, 0);
      px("R10 sleeping RAM transparent 2", 3, 3);
      @(negedge clk);
      ram_sleep = 1'b0;
      fill_model();
      idle(4);
      @(negedge clk);
      ram_addr = '0; ram_addr_ld = 1'b1;
      @(negedge clk);
      ram_addr_ld = 1'b0; ram_wdata = 8'hFF; ram_wr = 1'b1;
      @(negedge clk);
      ram_wr = 1'b0;
      idle(2 * T_TOTAL);
      px("R9 write during refill dropped", 0, 0);
      px("R9 refill after sleep", 3, 3);
      px("R9 refill after sleep row 2", 1, 2);

      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule